// File: doc/BRIEF.md
# Hardware-Update Gated Register Block

This block is a small register file reached through an APB3 slave port. It has five 32-bit words: one control word and four data words. Each data word carries an 8-bit field that on-chip logic can change. Logic outside the block can change a field in three ways: load a value, clear bits, or set bits. Every such change is filtered bit by bit, so only some bits of the field move. The filter is either an allow vector, where a 1 lets the bit change, or a block vector, where a 1 freezes the bit. Both vectors live in the control word.

The four fields differ in where their strobes come from:
- The first field takes its strobes from its own input pins and filters them through the allow vector. Software cannot write it.
- The second field also takes its strobes from its own pins, but filters them through the block vector. Software cannot write it.
- The third field takes its clear, set and load strobes from three bits of the control word and filters them through the allow vector. Software can write it.
- The fourth field captures its input while an active-low capture bit in the control word is held at 0. Software can write it.

Current field values are driven on output ports. Accesses always complete in the access phase, with no wait states.

Top module: `hwgate_regblk`

## Requirements
- R1: Synchronous active-high reset returns the control word to 0x001000FF and sets the fields at byte addresses 0x04, 0x08, 0x0C and 0x10 to 0x11, 0x22, 0x33 and 0x44. The reset values also appear on the field output ports.
- R2: The field at 0x04 is filtered by the allow vector (control bits 7:0).
  - A load strobe copies only the allowed bits of the input: 0x11 loaded with 0xAB under allow 0xF0 gives 0xA1.
  - A clear strobe zeroes only the allowed bits: 0xA1 becomes 0x01.
  - A set strobe raises only the allowed bits: 0x01 becomes 0xF1.
- R3: The field at 0x08 is filtered by the block vector (control bits 15:8), where bits set to 1 are frozen. Under block 0xF0, loading 0xAB into 0x22 gives 0x2B, a clear then gives 0x20, and a set then gives 0x2F.
- R4: The field at 0x0C takes its strobes from the control word, filtered by the allow vector: clear from bit 16, set from bit 17, load from bit 18. Each strobe acts on every cycle in which its bit is 1.
  - Raising clear under allow 0xF0 turns 0x33 into 0x03.
  - Raising set under allow 0x0F then gives 0x0F.
  - Raising load with input 0xAA under allow 0x0F then gives 0x0A.
- R5: The field at 0x10 captures its input on every cycle in which control bit 20 is 0. Dropping bit 20 and raising it again captures 0xBB; repeating the pulse captures 0xCC.
- R6: When strobes coincide, clear wins over set, and set wins over load.
- R7: Any hardware update wins over a software write to the same field in the same cycle. When no hardware update is active, a software write to 0x0C or 0x10 stores the low byte.
- R8: Software writes to 0x04 and 0x08 leave those fields unchanged.
- R9: Reads return zero for the following addresses:
  - word addresses above 0x10;
  - addresses whose two low bits are not zero.
- R10: The control word stores only bits 20, 18:16 and 15:0; every other bit reads as zero. Writing 0xFFFFFFFF reads back as 0x0017FFFF.
- R11: PREADY is high in every access phase. A write takes effect at the end of its access phase, so an immediately following read returns the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 8 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always high |
| fa_val | input | 8 | Load value for field 0x04 |
| fa_load | input | 1 | Load strobe for field 0x04 |
| fa_clr | input | 1 | Clear strobe for field 0x04 |
| fa_set | input | 1 | Set strobe for field 0x04 |
| fb_val | input | 8 | Load value for field 0x08 |
| fb_load | input | 1 | Load strobe for field 0x08 |
| fb_clr | input | 1 | Clear strobe for field 0x08 |
| fb_set | input | 1 | Set strobe for field 0x08 |
| fc_val | input | 8 | Load value for field 0x0C |
| fd_val | input | 8 | Capture value for field 0x10 |
| fa_q | output | 8 | Field 0x04 value |
| fb_q | output | 8 | Field 0x08 value |
| fc_q | output | 8 | Field 0x0C value |
| fd_q | output | 8 | Field 0x10 value |

## Verification
The assertions rely on three things about the inputs:
- APB traffic is well formed: PENABLE rises only after a setup cycle with PSEL high, and address and data stay steady through the access phase.
- The hardware strobe pins are known (not X) at every clock edge.
- Reset is held high for at least one edge.

The stimulus changes every input on the falling clock edge, so these conditions hold. Each bus transfer is one setup cycle followed by one access cycle, and strobes are raised for exactly one rising edge.

// File: rtl/hwgate_pkg.sv
package hwgate_pkg;

  localparam int FIELD_W    = 8;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 8;
  localparam int NUM_FIELDS = 4;
  localparam int NUM_REGS   = NUM_FIELDS + 1;
  localparam int IDX_W      = ADDR_W - 2;

  // control word bit positions (decoded by field logic)
  localparam int BLOCK_LSB = FIELD_W;
  localparam int BIT_CLR   = 2 * FIELD_W;
  localparam int BIT_SET   = BIT_CLR + 1;
  localparam int BIT_LOAD  = BIT_CLR + 2;
  localparam int BIT_HOLDN = BIT_CLR + 4;

  typedef enum logic {GATE_ALLOW = 1'b0, GATE_BLOCK = 1'b1} gate_mode_e;

  typedef struct packed {
    logic               hold_n;
    logic               do_load;
    logic               do_set;
    logic               do_clr;
    logic [FIELD_W-1:0] block;
    logic [FIELD_W-1:0] allow;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] ctrl_keep_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < 2 * FIELD_W; i++) m[i] = 1'b1;
    m[BIT_CLR]   = 1'b1;
    m[BIT_SET]   = 1'b1;
    m[BIT_LOAD]  = 1'b1;
    m[BIT_HOLDN] = 1'b1;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] ctrl_reset_word();
    logic [DATA_W-1:0] w;
    w = '0;
    for (int i = 0; i < FIELD_W; i++) w[i] = 1'b1;
    w[BIT_HOLDN] = 1'b1;
    return w;
  endfunction

  localparam logic [DATA_W-1:0] CTRL_KEEP  = ctrl_keep_mask();
  localparam logic [DATA_W-1:0] CTRL_RESET = ctrl_reset_word();

  function automatic ctrl_t word_to_ctrl(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.allow   = w[FIELD_W-1:0];
    c.block   = w[BLOCK_LSB +: FIELD_W];
    c.do_clr  = w[BIT_CLR];
    c.do_set  = w[BIT_SET];
    c.do_load = w[BIT_LOAD];
    c.hold_n  = w[BIT_HOLDN];
    return c;
  endfunction

  // bitwise merge: gated bits take the new value, the rest keep the old one
  function automatic logic [FIELD_W-1:0] hw_merge(input logic [FIELD_W-1:0] old_v,
                                                   input logic [FIELD_W-1:0] new_v,
                                                   input logic [FIELD_W-1:0] gate);
    return (new_v & gate) | (old_v & ~gate);
  endfunction

  function automatic logic [FIELD_W-1:0] field_reset(input int idx);
    return FIELD_W'(8'h11 * (idx + 1));
  endfunction

endpackage

// File: rtl/hwgate_apb_decode.sv
module hwgate_apb_decode
  import hwgate_pkg::*;
(
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output logic [NUM_REGS-1:0] sel,
  output logic [NUM_REGS-1:0] wr_sel,
  output logic              rd_hit,
  output logic              wr_access
);

  logic             aligned;
  logic [IDX_W-1:0] word_idx;

  assign aligned   = (paddr[1:0] == 2'b00);
  assign word_idx  = paddr[ADDR_W-1:2];
  assign wr_access = psel & penable & pwrite;

  generate
    for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
      assign sel[r]    = aligned && (word_idx == IDX_W'(r));
      assign wr_sel[r] = sel[r] & wr_access;
    end
  endgenerate

  assign rd_hit = |sel;

  // R11: at most one register is written per access
  always_comb begin
    assert_onehot_wr_R11: assert ($onehot0(wr_sel) || $isunknown(wr_sel));
  end

endmodule

// File: rtl/hwgate_ctrl_reg.sv
module hwgate_ctrl_reg
  import hwgate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] word,
  output ctrl_t             ctrl
);

  always_ff @(posedge clk) begin
    if (rst)     word <= CTRL_RESET;
    else if (we) word <= wdata & CTRL_KEEP;
  end

  assign ctrl = word_to_ctrl(word);

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (word == CTRL_RESET));

  assert_unused_zero_R10: assert property (@(posedge clk) disable iff (rst)
    (word & ~CTRL_KEEP) == '0);

endmodule

// File: rtl/hwgate_field.sv
module hwgate_field
  import hwgate_pkg::*;
#(
  parameter logic [FIELD_W-1:0] RESET_VAL   = '0,
  parameter bit                 SW_WRITABLE = 1'b1,
  parameter gate_mode_e         MODE        = GATE_ALLOW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FIELD_W-1:0] gate_vec,
  input  logic [FIELD_W-1:0] hw_val,
  input  logic               hw_ld,
  input  logic               hw_cl,
  input  logic               hw_st,
  input  logic               sw_we,
  input  logic [FIELD_W-1:0] sw_data,
  output logic [FIELD_W-1:0] q
);

  logic [FIELD_W-1:0] eff_gate;   // bits allowed to move on a hardware update
  logic               hw_any;     // any hardware update this cycle
  logic [FIELD_W-1:0] nxt;

  generate
    if (MODE == GATE_BLOCK) begin : g_block
      assign eff_gate = ~gate_vec;
    end else begin : g_allow
      assign eff_gate = gate_vec;
    end
  endgenerate

  assign hw_any = hw_ld | hw_cl | hw_st;

  always_comb begin
    nxt = q;
    if (hw_cl)                     nxt = hw_merge(q, '0, eff_gate);
    else if (hw_st)                nxt = hw_merge(q, '1, eff_gate);
    else if (hw_ld)                nxt = hw_merge(q, hw_val, eff_gate);
    else if (sw_we && SW_WRITABLE) nxt = sw_data;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= RESET_VAL;
    else     q <= nxt;
  end

  // R2 / R3: gated-off bits never move on a hardware update
  assert_gate_hold_R2: assert property (@(posedge clk) disable iff (rst)
    hw_any |=> (((q ^ $past(q)) & ~$past(eff_gate)) == '0));

  // R6: clear wins over everything
  assert_clear_wins_R6: assert property (@(posedge clk) disable iff (rst)
    hw_cl |=> ((q & $past(eff_gate)) == '0));

  // R6: set wins over load
  assert_set_over_load_R6: assert property (@(posedge clk) disable iff (rst)
    (hw_st && !hw_cl) |=> ((q & $past(eff_gate)) == $past(eff_gate)));

  generate
    if (!SW_WRITABLE) begin : g_ro_chk
      assert_sw_ignored_R8: assert property (@(posedge clk) disable iff (rst)
        (sw_we && !hw_any) |=> $stable(q));
    end else begin : g_rw_chk
      assert_hw_beats_sw_R7: assert property (@(posedge clk) disable iff (rst)
        (sw_we && hw_any) |=> (((q ^ $past(q)) & ~$past(eff_gate)) == '0));
    end
  endgenerate

endmodule

// File: rtl/hwgate_regblk.sv
module hwgate_regblk
  import hwgate_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [DATA_W-1:0]  pwdata,
  output logic [DATA_W-1:0]  prdata,
  output logic               pready,
  input  logic [FIELD_W-1:0] fa_val,
  input  logic               fa_load,
  input  logic               fa_clr,
  input  logic               fa_set,
  input  logic [FIELD_W-1:0] fb_val,
  input  logic               fb_load,
  input  logic               fb_clr,
  input  logic               fb_set,
  input  logic [FIELD_W-1:0] fc_val,
  input  logic [FIELD_W-1:0] fd_val,
  output logic [FIELD_W-1:0] fa_q,
  output logic [FIELD_W-1:0] fb_q,
  output logic [FIELD_W-1:0] fc_q,
  output logic [FIELD_W-1:0] fd_q
);

  logic [NUM_REGS-1:0] sel;
  logic [NUM_REGS-1:0] wr_sel;
  logic                rd_hit;
  logic                wr_access;
  logic [DATA_W-1:0]   ctrl_word;
  ctrl_t               ctrl;
  logic [DATA_W-1:0]   rd_word;

  logic [FIELD_W-1:0]  f_gate [NUM_FIELDS];
  logic [FIELD_W-1:0]  f_val  [NUM_FIELDS];
  logic                f_ld   [NUM_FIELDS];
  logic                f_cl   [NUM_FIELDS];
  logic                f_st   [NUM_FIELDS];
  logic [FIELD_W-1:0]  f_q    [NUM_FIELDS];

  assign pready = 1'b1;

  hwgate_apb_decode u_decode (
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .sel       (sel),
    .wr_sel    (wr_sel),
    .rd_hit    (rd_hit),
    .wr_access (wr_access)
  );

  hwgate_ctrl_reg u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_sel[0]),
    .wdata (pwdata),
    .word  (ctrl_word),
    .ctrl  (ctrl)
  );

  // per-field source routing
  always_comb begin
    f_gate[0] = ctrl.allow; f_val[0] = fa_val; f_ld[0] = fa_load;
    f_cl[0]   = fa_clr;     f_st[0]  = fa_set;

    f_gate[1] = ctrl.block; f_val[1] = fb_val; f_ld[1] = fb_load;
    f_cl[1]   = fb_clr;     f_st[1]  = fb_set;

    f_gate[2] = ctrl.allow;  f_val[2] = fc_val; f_ld[2] = ctrl.do_load;
    f_cl[2]   = ctrl.do_clr; f_st[2]  = ctrl.do_set;

    f_gate[3] = '1;    f_val[3] = fd_val; f_ld[3] = ~ctrl.hold_n;
    f_cl[3]   = 1'b0;  f_st[3]  = 1'b0;
  end

  generate
    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_field
      localparam gate_mode_e MODE_I = (i == 1) ? GATE_BLOCK : GATE_ALLOW;
      localparam bit         SWW_I  = (i >= 2);
      hwgate_field #(
        .RESET_VAL   (field_reset(i)),
        .SW_WRITABLE (SWW_I),
        .MODE        (MODE_I)
      ) u_field (
        .clk      (clk),
        .rst      (rst),
        .gate_vec (f_gate[i]),
        .hw_val   (f_val[i]),
        .hw_ld    (f_ld[i]),
        .hw_cl    (f_cl[i]),
        .hw_st    (f_st[i]),
        .sw_we    (wr_sel[i+1]),
        .sw_data  (pwdata[FIELD_W-1:0]),
        .q        (f_q[i])
      );
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    if (sel[0]) rd_word = rd_word | ctrl_word;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      if (sel[i+1]) rd_word = rd_word | DATA_W'(f_q[i]);
    end
  end

  assign prdata = rd_word;
  assign fa_q   = f_q[0];
  assign fb_q   = f_q[1];
  assign fc_q   = f_q[2];
  assign fd_q   = f_q[3];

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (psel && !pwrite && !rd_hit) |-> (prdata == '0));

  // R5: capture bit low means the capture field follows its input next cycle
  assert_capture_R5: assert property (@(posedge clk) disable iff (rst)
    !ctrl.hold_n |=> (fd_q == $past(fd_val)));

endmodule

// File: tb/hwgate_regblk_tb.sv
module hwgate_regblk_tb;

  localparam logic [2:0] K_WR = 3'd0;  // APB write addr,data
  localparam logic [2:0] K_RD = 3'd1;  // APB read addr, expect data
  localparam logic [2:0] K_HA = 3'd2;  // pulse field A strobes: [10]clr [9]set [8]load [7:0]value
  localparam logic [2:0] K_HB = 3'd3;  // same for field B
  localparam logic [2:0] K_HV = 3'd4;  // set fc_val=[7:0], fd_val=[15:8]

  typedef struct packed {
    logic [2:0]  kind;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 59;
  localparam vec_t VECS [NV] = '{
    '{K_RD, 8'h00, 32'h0010_00FF, 4'd1},  // R1
    '{K_RD, 8'h04, 32'h11, 4'd1},
    '{K_RD, 8'h08, 32'h22, 4'd1},
    '{K_RD, 8'h0C, 32'h33, 4'd1},
    '{K_RD, 8'h10, 32'h44, 4'd1},
    '{K_WR, 8'h00, 32'h0010_00F0, 4'd2},  // R2 allow=F0
    '{K_HA, 8'h00, 32'h1AB, 4'd2},
    '{K_RD, 8'h04, 32'hA1, 4'd2},
    '{K_HA, 8'h00, 32'h400, 4'd2},
    '{K_RD, 8'h04, 32'h01, 4'd2},
    '{K_HA, 8'h00, 32'h200, 4'd2},
    '{K_RD, 8'h04, 32'hF1, 4'd2},
    '{K_WR, 8'h00, 32'h0010_F000, 4'd3},  // R3 block=F0
    '{K_HB, 8'h00, 32'h1AB, 4'd3},
    '{K_RD, 8'h08, 32'h2B, 4'd3},
    '{K_HB, 8'h00, 32'h400, 4'd3},
    '{K_RD, 8'h08, 32'h20, 4'd3},
    '{K_HB, 8'h00, 32'h200, 4'd3},
    '{K_RD, 8'h08, 32'h2F, 4'd3},
    '{K_WR, 8'h00, 32'h0011_00F0, 4'd4},  // R4 clear, allow F0
    '{K_WR, 8'h00, 32'h0010_0000, 4'd4},
    '{K_RD, 8'h0C, 32'h03, 4'd4},
    '{K_WR, 8'h00, 32'h0012_000F, 4'd4},  // R4 set, allow 0F
    '{K_WR, 8'h00, 32'h0010_0000, 4'd4},
    '{K_RD, 8'h0C, 32'h0F, 4'd4},
    '{K_HV, 8'h00, 32'hBBAA, 4'd4},
    '{K_WR, 8'h00, 32'h0014_000F, 4'd4},  // R4 load, allow 0F
    '{K_WR, 8'h00, 32'h0010_0000, 4'd4},
    '{K_RD, 8'h0C, 32'h0A, 4'd4},
    '{K_WR, 8'h00, 32'h0000_0000, 4'd5},  // R5 capture pulse
    '{K_WR, 8'h00, 32'h0010_0000, 4'd5},
    '{K_RD, 8'h10, 32'hBB, 4'd5},
    '{K_HV, 8'h00, 32'hCCAA, 4'd5},
    '{K_WR, 8'h00, 32'h0000_0000, 4'd5},
    '{K_WR, 8'h00, 32'h0010_0000, 4'd5},
    '{K_RD, 8'h10, 32'hCC, 4'd5},
    '{K_WR, 8'h04, 32'h55, 4'd8},         // R8 read-only fields
    '{K_RD, 8'h04, 32'hF1, 4'd8},
    '{K_WR, 8'h08, 32'h55, 4'd8},
    '{K_RD, 8'h08, 32'h2F, 4'd8},
    '{K_WR, 8'h00, 32'h0000_0000, 4'd7},  // R7 capture held active
    '{K_WR, 8'h10, 32'h99, 4'd7},
    '{K_RD, 8'h10, 32'hCC, 4'd7},
    '{K_WR, 8'h00, 32'h0010_0000, 4'd7},
    '{K_WR, 8'h10, 32'h99, 4'd7},
    '{K_RD, 8'h10, 32'h99, 4'd7},
    '{K_WR, 8'h0C, 32'h5A, 4'd7},
    '{K_RD, 8'h0C, 32'h5A, 4'd7},
    '{K_RD, 8'h14, 32'h0, 4'd9},          // R9 unmapped
    '{K_RD, 8'hFC, 32'h0, 4'd9},
    '{K_RD, 8'h05, 32'h0, 4'd9},
    '{K_WR, 8'h00, 32'hFFFF_FFFF, 4'd10}, // R10 unused bits
    '{K_RD, 8'h00, 32'h0017_FFFF, 4'd10},
    '{K_RD, 8'h0C, 32'h00, 4'd6},         // R6 clear beats set and load
    '{K_WR, 8'h00, 32'h0010_00FF, 4'd10},
    '{K_HA, 8'h00, 32'h7AB, 4'd6},        // R6 all three strobes
    '{K_RD, 8'h04, 32'h00, 4'd6},
    '{K_HA, 8'h00, 32'h3AB, 4'd6},        // R6 set + load
    '{K_RD, 8'h04, 32'hFF, 4'd6}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready;
  logic [7:0]  fa_val = '0, fb_val = '0, fc_val = '0, fd_val = '0;
  logic        fa_load = 1'b0, fa_clr = 1'b0, fa_set = 1'b0;
  logic        fb_load = 1'b0, fb_clr = 1'b0, fb_set = 1'b0;
  logic [7:0]  fa_q, fb_q, fc_q, fd_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  hwgate_regblk u_dut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .fa_val(fa_val), .fa_load(fa_load), .fa_clr(fa_clr), .fa_set(fa_set),
    .fb_val(fb_val), .fb_load(fb_load), .fb_clr(fb_clr), .fb_set(fb_set),
    .fc_val(fc_val), .fd_val(fd_val),
    .fa_q(fa_q), .fb_q(fb_q), .fc_q(fc_q), .fd_q(fd_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [7:0] a, input int req, input logic [31:0] exp);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
    @(negedge clk);
    penable = 1'b1;
    #4;
    check($sformatf("R%0d read 0x%02h", req, a), prdata, exp);
    check("R11 pready in access phase", {31'd0, pready}, 32'd1);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic hw_pulse(input bit on_b, input logic [31:0] d);
    @(negedge clk);
    if (!on_b) begin
      fa_val = d[7:0]; fa_load = d[8]; fa_set = d[9]; fa_clr = d[10];
    end else begin
      fb_val = d[7:0]; fb_load = d[8]; fb_set = d[9]; fb_clr = d[10];
    end
    @(negedge clk);
    fa_load = 1'b0; fa_set = 1'b0; fa_clr = 1'b0;
    fb_load = 1'b0; fb_set = 1'b0; fb_clr = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 outputs after reset
    #1;
    check("R1 fa_q reset", {24'd0, fa_q}, 32'h11);
    check("R1 fd_q reset", {24'd0, fd_q}, 32'h44);

    for (int i = 0; i < NV; i++) begin
      case (VECS[i].kind)
        K_WR: apb_write(VECS[i].addr, VECS[i].data);
        K_RD: apb_read(VECS[i].addr, int'(VECS[i].req), VECS[i].data);
        K_HA: hw_pulse(1'b0, VECS[i].data);
        K_HB: hw_pulse(1'b1, VECS[i].data);
        default: begin
          @(negedge clk);
          fc_val = VECS[i].data[7:0];
          fd_val = VECS[i].data[15:8];
        end
      endcase
    end

    // R2 output port agrees with bus view (field A now 0xFF)
    #1;
    check("R2 fa_q port", {24'd0, fa_q}, 32'hFF);
    check("R3 fb_q port", {24'd0, fb_q}, 32'h2F);

    // R11 read straight after write
    apb_write(8'h0C, 32'h3C);
    apb_read(8'h0C, 11, 32'h3C);

    // R1 mid-run reset
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    check("R1 fa_q after reset", {24'd0, fa_q}, 32'h11);
    check("R1 fb_q after reset", {24'd0, fb_q}, 32'h22);
    check("R1 fc_q after reset", {24'd0, fc_q}, 32'h33);
    check("R1 fd_q after reset", {24'd0, fd_q}, 32'h44);
    apb_read(8'h00, 1, 32'h0010_00FF);

    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

endmodule